// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a 32-bit down-counter for one processor's local interrupt controller. Software sets it up through a small word-wide register port. The registers hold a timer control entry (an interrupt vector, a mask bit and a repeat-mode bit), a starting count, a prescaler setting, and a read-only current count. The prescaler divides the core clock by a power of two, and each prescaled tick lowers the count by one.

When the count reaches zero the block raises `irq_valid` for exactly one clock and places the entry's vector on `irq_vector`. This happens only if the entry is not masked. A single-shot timer then stays at zero. A repeating timer goes back to its starting value on the next tick, so one period lasts start+1 ticks.

Top module: `lapic_timer`

## Requirements
- R1: While running, the current count drops by exactly one on each prescaled tick. With divide ratio N, the first decrement happens N clock edges after the starting-count write, so k edges after that write the count reads start − floor(k/N) (until it reaches zero).
- R2: A write to address 3 keeps only bits 3, 1 and 0 (mask 0xB), and a read of address 3 returns those kept bits. The code {bit3, bit1, bit0} gives a prescaler shift of (code+1) mod 8. For example, 0x0 divides by 2, 0x8 by 32, 0xA by 128 and 0xB by 1.
- R3: A write to address 1 sets the starting count. The current count equals the written value in the cycle after the write, and the prescaler phase restarts at that moment.
- R4: In single-shot mode (entry bit 17 = 0) the count stops at zero and stays there. The expiry pulse lasts exactly one cycle and appears in the same cycle the count first reads zero.
- R5: In repeating mode (entry bit 17 = 1) a tick at zero reloads the starting count. Every arrival at zero produces one pulse.
- R6: Entry bits 7:0 are the vector driven on `irq_vector` with the pulse. Entry bit 16 set suppresses the pulse, but counting carries on.
- R7: Writes to address 2 (current count) change nothing.
- R8: After reset the entry reads 0x0001_0000 (masked, single-shot, vector 0), the starting and current counts read 0, the divide setting reads 0 (divide by 2), and `irq_valid` is low.
- R9: A starting count of zero stops the timer. The current count stays at zero and no pulse is produced, whatever the mode.
- R10: A starting-count write in the same cycle that a tick would bring the count to zero takes priority. The count loads the new value and no pulse is produced.
- R11: Writing the entry at address 0 re-evaluates whether the timer runs. A single-shot timer that has ended and is switched to repeating mode reloads its starting count on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 entry, 1 starting count, 2 current count, 3 divide |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle expiry pulse |
| irq_vector | output | 8 | Vector carried with the pulse |

## Verification
The collision of interest is a starting-count write landing on the very edge where a tick would take the count from one to zero. The bench uses divide-by-one and counts edges from a known write, so the rewrite lands exactly on the expiring edge. The pass criterion is that the count holds the new value, no pulse appears in that cycle, and the following countdown still ends in exactly one pulse. A second overlap is also covered: an entry rewrite arriving while a finished single-shot timer sits at zero, where the bench looks for a reload one tick later.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;
    localparam int CNT_W   = 32;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int WORD_W  = 32;

    localparam logic [1:0] A_ENTRY = 2'd0;
    localparam logic [1:0] A_START = 2'd1;
    localparam logic [1:0] A_CURR  = 2'd2;
    localparam logic [1:0] A_DIV   = 2'd3;

    localparam int MASK_BIT   = 16;
    localparam int REPEAT_BIT = 17;

    localparam logic [WORD_W-1:0] ENTRY_KEEP = 32'h0003_00FF;
    localparam logic [WORD_W-1:0] DIV_KEEP   = 32'h0000_000B;
    localparam logic [WORD_W-1:0] ENTRY_RST  = 32'h0001_0000;
endpackage

// File: rtl/lapic_timer_prescaler.sv
module lapic_timer_prescaler
    import lapic_timer_pkg::*;
#(
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [SW-1:0] shift,
    output logic          tick
);
    localparam int PW = (1 << SW) - 1;

    logic [PW-1:0] ph_d, ph_q;
    logic [PW:0]   full_mask;
    logic [PW-1:0] sel_mask;

    always_comb begin
        full_mask = ((PW+1)'(1) << shift) - (PW+1)'(1);
        sel_mask  = full_mask[PW-1:0];
        tick      = ((ph_q & sel_mask) == sel_mask);
        ph_d      = restart ? '0 : ph_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    // R3: the phase is back at zero right after a restart
    assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ph_q == '0));
endmodule

// File: rtl/lapic_timer_counter.sv
module lapic_timer_counter
    import lapic_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         repeat_mode,
    output logic [W-1:0] start_val,
    output logic [W-1:0] cur_val,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] start;
        logic [W-1:0] cur;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    active;

    always_comb begin
        st_d   = st_q;
        active = (st_q.start != '0) && (repeat_mode || (st_q.cur != '0));
        expire = 1'b0;
        if (load) begin
            st_d.start = load_val;
            st_d.cur   = load_val;
        end else if (tick && active) begin
            if (st_q.cur == '0) begin
                st_d.cur = st_q.start;
            end else begin
                st_d.cur = st_q.cur - W'(1);
                expire   = (st_q.cur == W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_val = st_q.start;
    assign cur_val   = st_q.cur;

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && st_q.cur != '0) |=> (st_q.cur == $past(st_q.cur) || st_q.cur == $past(st_q.cur) - W'(1)));

    assert_oneshot_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !repeat_mode && st_q.cur == '0) |=> (st_q.cur == '0));

    assert_zero_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start == '0) |-> (st_q.cur == '0));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cur == $past(load_val)));
endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
    import lapic_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    typedef struct packed {
        logic [WORD_W-1:0] entry;
        logic [WORD_W-1:0] div;
        logic              irq;
        logic [VEC_W-1:0]  vec;
    } top_st_t;

    top_st_t st_d, st_q;

    logic               start_wr;
    logic [SHIFT_W-1:0] code, shift;
    logic               tick, expire;
    logic [CNT_W-1:0]   start_val, cur_val;

    assign start_wr = wr_en && (wr_addr == A_START);
    assign code     = {st_q.div[3], st_q.div[1:0]};
    assign shift    = code + SHIFT_W'(1);

    lapic_timer_prescaler #(.SW(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_wr),
        .shift   (shift),
        .tick    (tick)
    );

    lapic_timer_counter #(.W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start_wr),
        .load_val    (wr_data[CNT_W-1:0]),
        .tick        (tick),
        .repeat_mode (st_q.entry[REPEAT_BIT]),
        .start_val   (start_val),
        .cur_val     (cur_val),
        .expire      (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = expire && !st_q.entry[MASK_BIT];
        st_d.vec = st_q.entry[VEC_W-1:0];
        if (wr_en && wr_addr == A_ENTRY) st_d.entry = wr_data & ENTRY_KEEP;
        if (wr_en && wr_addr == A_DIV)   st_d.div   = wr_data & DIV_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.entry <= ENTRY_RST;
            st_q.div   <= '0;
            st_q.irq   <= 1'b0;
            st_q.vec   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_ENTRY: rd_data = st_q.entry;
            A_START: rd_data = start_val;
            A_CURR:  rd_data = cur_val;
            default: rd_data = st_q.div;
        endcase
    end

    assign irq_valid  = st_q.irq;
    assign irq_vector = st_q.vec;

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    assert_pulse_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (cur_val == '0));

    assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(st_q.entry[MASK_BIT]));

    assert_start_write_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> !irq_valid);
endmodule

// File: tb/lapic_timer_bench.sv
`timescale 1ns/1ps
module lapic_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [7:0] last_vec = '0;

    always #2 clk = ~clk;

    lapic_timer u_lapic_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always begin
        @(posedge clk);
        #1;
        if (irq_valid) begin
            pulses++;
            last_vec = irq_vector;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] entry, input logic [31:0] dv);
        wr(2'd1, 32'd0);
        wr(2'd0, entry);
        wr(2'd3, dv);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R8 entry", v, 32'h0001_0000);
        rd(2'd1, v); chk("R8 start", v, 0);
        rd(2'd2, v); chk("R8 current", v, 0);
        rd(2'd3, v); chk("R8 divide", v, 0);
        chk("R8 irq", {31'd0, irq_valid}, 0);
    endtask

    task automatic t_oneshot_div2;
        logic [31:0] v;
        int p0;
        setup(32'h0000_0041, 32'h0);
        wr(2'd1, 32'd3);
        p0 = pulses;
        rd(2'd2, v); chk("R3 load value", v, 3);
        step(2); rd(2'd2, v); chk("R1 div2 k=2", v, 2);
        step(3); rd(2'd2, v); chk("R1 div2 k=5", v, 1);
        step(1); rd(2'd2, v); chk("R4 zero at k=6", v, 0);
        chk("R4 pulse at zero", {31'd0, irq_valid}, 1);
        chk("R6 vector", {24'd0, irq_vector}, 32'h41);
        step(1); chk("R4 pulse ends", {31'd0, irq_valid}, 0);
        step(20); rd(2'd2, v); chk("R4 stays zero", v, 0);
        chk("R4 one pulse", pulses - p0, 1);
    endtask

    task automatic t_divides;
        logic [31:0] v;
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R2 kept bits", v, 32'hB);
        setup(32'h0001_0000, 32'h8);
        wr(2'd1, 32'd1);
        step(31); rd(2'd2, v); chk("R2 div32 k=31", v, 1);
        step(1);  rd(2'd2, v); chk("R2 div32 k=32", v, 0);
        setup(32'h0001_0000, 32'hA);
        wr(2'd1, 32'd1);
        step(127); rd(2'd2, v); chk("R2 div128 k=127", v, 1);
        step(1);   rd(2'd2, v); chk("R2 div128 k=128", v, 0);
        setup(32'h0001_0000, 32'hB);
        wr(2'd1, 32'd5);
        step(2); rd(2'd2, v); chk("R2 div1 k=2", v, 3);
        wr(2'd3, 32'h4);
        rd(2'd3, v); chk("R2 bit2 dropped", v, 0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        int p0;
        setup(32'h0002_0033, 32'hB);
        wr(2'd1, 32'd2);
        p0 = pulses;
        step(2); rd(2'd2, v); chk("R5 reach zero", v, 0);
        chk("R5 pulse", {31'd0, irq_valid}, 1);
        step(1); rd(2'd2, v); chk("R5 reload", v, 2);
        step(3); chk("R5 two pulses", pulses - p0, 2);
        chk("R6 periodic vector", {24'd0, last_vec}, 32'h33);
    endtask

    task automatic t_masked;
        logic [31:0] v;
        int p0;
        setup(32'h0001_0077, 32'hB);
        wr(2'd1, 32'd2);
        p0 = pulses;
        step(10); rd(2'd2, v); chk("R6 masked counts", v, 0);
        chk("R6 masked no pulse", pulses - p0, 0);
    endtask

    task automatic t_cur_write;
        logic [31:0] v;
        setup(32'h0001_0000, 32'hB);
        wr(2'd1, 32'd10);
        step(2);
        wr(2'd2, 32'h55);
        rd(2'd2, v); chk("R7 current unchanged", v, 7);
        rd(2'd1, v); chk("R7 start unchanged", v, 10);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        setup(32'h0001_0000, 32'hB);
        wr(2'd1, 32'd10);
        step(3);
        wr(2'd1, 32'd5);
        rd(2'd2, v); chk("R3 restart value", v, 5);
        step(1); rd(2'd2, v); chk("R3 restart decrement", v, 4);
    endtask

    task automatic t_zero_start;
        logic [31:0] v;
        int p0;
        setup(32'h0002_0011, 32'hB);
        p0 = pulses;
        step(20); rd(2'd2, v); chk("R9 stays zero", v, 0);
        chk("R9 no pulse", pulses - p0, 0);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        int p0;
        setup(32'h0000_0055, 32'hB);
        wr(2'd1, 32'd3);
        p0 = pulses;
        step(2);
        wr(2'd1, 32'd4);
        chk("R10 no pulse on collision", {31'd0, irq_valid}, 0);
        rd(2'd2, v); chk("R10 new value", v, 4);
        chk("R10 no pulse counted", pulses - p0, 0);
        step(4); rd(2'd2, v); chk("R10 later zero", v, 0);
        chk("R10 later single pulse", pulses - p0, 1);
    endtask

    task automatic t_reeval;
        logic [31:0] v;
        setup(32'h0000_0022, 32'hB);
        wr(2'd1, 32'd2);
        step(4); rd(2'd2, v); chk("R11 ended at zero", v, 0);
        wr(2'd0, 32'h0002_0022);
        rd(2'd2, v); chk("R11 still zero", v, 0);
        step(1); rd(2'd2, v); chk("R11 reload", v, 2);
        step(2); chk("R11 pulse again", {31'd0, irq_valid}, 1);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot_div2();
        t_divides();
        t_periodic();
        t_masked();
        t_cur_write();
        t_restart();
        t_zero_start();
        t_collision();
        t_reeval();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule